// File: doc/BRIEF.md
# Instruction Cycle Count Calculator

This block works out how many bus cycles one instruction of a 16-bit-extended 6502-family core takes. The decode stage gives it an instruction class and an addressing-mode code. It also takes the current status flags: accumulator width, index width and emulation mode. It also takes the low byte of the direct-page register and a flag from the address generator that says indexing crossed a page. One clock later it returns the cycle count, or an illegal flag when the class and mode pair is not supported.

The count is a base value taken from the class and mode, plus up to five independent one-cycle penalties:
- a wide accumulator
- a wide index register
- native mode for trap and return instructions
- a direct page that is not page aligned
- an indexed read that crosses a page

A scheduler or cycle-accurate model can use the result to pace the bus sequencer or to keep a cycle budget.

Top module: `cyc_count_calc`

## Requirements
- R1: While rst_ni is low and after it is released, before any request, valid_o, cycles_o and illegal_o are all 0.
- R2: A request presented with valid_i=1 produces its result on the next rising edge with valid_o=1. A cycle with valid_i=0 gives valid_o=0, cycles_o=0 and illegal_o=0 after the next edge.
- R3: For class 0 (accumulator read: load or ALU), the base counts are: mode 1 immediate 2, mode 2 absolute 4, mode 3 absolute long 5, mode 4 direct 3, mode 5 direct indirect 5, mode 6 direct indirect long 6, mode 7 absolute,X 4, mode 8 absolute long,X 5, mode 9 absolute,Y 4, mode 10 direct,X 4, mode 11 direct,X indirect 6, mode 12 direct indirect,Y 5, mode 13 direct indirect long,Y 6, mode 14 stack relative 4, mode 15 stack relative indirect,Y 7.
- R4: flag_m_i=0 (16-bit accumulator) adds 1 cycle for classes 0, 1, 5 and 11. flag_x_i=0 (16-bit index) adds 1 cycle for classes 2, 6 and 12. No other class takes a width penalty.
- R5: If dp_low_i is nonzero, modes 4, 5, 6, 10, 11, 12, 13, 17 (direct,Y) and 18 (direct,Y for index reads) add 1 cycle. No other mode takes this penalty.
- R6: page_cross_i=1 adds 1 cycle only for class 0 in modes 7, 9 and 12, and for class 2 in modes 7 and 9. In every other case it has no effect.
- R7: For class 1 (accumulator store), the counts follow R3 except for these: modes 7 and 9 are 5, mode 12 is 6, and mode 1 is illegal.
- R8: Class 3 (software break or coprocessor trap) takes 7 cycles and class 4 (return from interrupt) takes 6. Each adds 1 when emu_i=0 (native mode).
- R9: Stack operations use mode 0. Pushes: class 5 A 3, class 6 X/Y 3, class 7 data bank 3, class 8 direct page 4, class 9 program bank 3, class 10 status 3. Pulls: class 11 A 4, class 12 X/Y 4, class 13 data bank 4, class 14 direct page 5, class 15 status 4.
- R10: For class 16 (subroutine call), mode 2 takes 6, mode 16 (absolute,X indirect) takes 8 and mode 3 takes 8. Class 17 (status bit set or reset) takes 3 in mode 0. Class 18 (single flag, transfer, index increment, emulation exchange) takes 2 in mode 0.
- R11: An unsupported pair gives illegal_o=1 and cycles_o=0. This covers class codes 19 to 31, mode codes 19 to 31, classes 3 to 15, 17 and 18 in any mode other than 0, and any mode not listed for classes 0, 1, 2 and 16.
- R12: For class 2 (index read or compare), the base counts are: mode 1 immediate 2, mode 2 absolute 4, mode 4 direct 3, mode 7 absolute,X 4, mode 9 absolute,Y 4, mode 10 direct,X 4, mode 18 direct,Y 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| class_i | input | 5 | Instruction class code |
| mode_i | input | 5 | Addressing-mode code |
| flag_m_i | input | 1 | Accumulator width flag, 1 = 8-bit |
| flag_x_i | input | 1 | Index width flag, 1 = 8-bit |
| emu_i | input | 1 | 1 = emulation mode |
| dp_low_i | input | 8 | Low byte of the direct-page register |
| page_cross_i | input | 1 | Indexed address crossed a page |
| valid_o | output | 1 | Result valid |
| cycles_o | output | 4 | Cycle count |
| illegal_o | output | 1 | Unsupported class and mode pair |

## Verification
The bench aims at the cases where penalties stack on one instruction. A direct indirect,Y read with a wide accumulator, an unaligned direct page and a page crossing must reach 8. An adder that drops a term, or that is one bit too narrow, would come up short. The bench also drives page crossing on stores and on non-indexed reads, and a nonzero direct page on absolute modes. A design that applies a penalty to too many modes would count one cycle too many there. Implicit classes get a non-implied mode and store gets immediate: a decoder that is too permissive would return a count where illegal_o should rise with a zero count.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
  localparam int unsigned CLS_W  = 5;
  localparam int unsigned MODE_W = 5;
  localparam int unsigned CNT_W  = 4;
  localparam int unsigned DP_W   = 8;
  localparam int unsigned NUM_PEN = 5;

  typedef enum logic [CLS_W-1:0] {
    CLS_ACC_RD   = 5'd0,
    CLS_ACC_ST   = 5'd1,
    CLS_IDX_RD   = 5'd2,
    CLS_TRAP     = 5'd3,
    CLS_RET_INT  = 5'd4,
    CLS_PSH_A    = 5'd5,
    CLS_PSH_IDX  = 5'd6,
    CLS_PSH_DB   = 5'd7,
    CLS_PSH_DP   = 5'd8,
    CLS_PSH_PB   = 5'd9,
    CLS_PSH_ST   = 5'd10,
    CLS_PUL_A    = 5'd11,
    CLS_PUL_IDX  = 5'd12,
    CLS_PUL_DB   = 5'd13,
    CLS_PUL_DP   = 5'd14,
    CLS_PUL_ST   = 5'd15,
    CLS_CALL     = 5'd16,
    CLS_STAT_BIT = 5'd17,
    CLS_SIMPLE   = 5'd18
  } cls_e;

  typedef enum logic [MODE_W-1:0] {
    AM_IMPL       = 5'd0,
    AM_IMM        = 5'd1,
    AM_ABS        = 5'd2,
    AM_ABS_L      = 5'd3,
    AM_DIR        = 5'd4,
    AM_DIR_IND    = 5'd5,
    AM_DIR_IND_L  = 5'd6,
    AM_ABS_X      = 5'd7,
    AM_ABS_L_X    = 5'd8,
    AM_ABS_Y      = 5'd9,
    AM_DIR_X      = 5'd10,
    AM_DIR_X_IND  = 5'd11,
    AM_DIR_IND_Y  = 5'd12,
    AM_DIR_INDL_Y = 5'd13,
    AM_STK        = 5'd14,
    AM_STK_IND_Y  = 5'd15,
    AM_ABS_X_IND  = 5'd16,
    AM_DIR_Y      = 5'd17,
    AM_DIR_Y_IDX  = 5'd18
  } mode_e;

  typedef struct packed {
    logic             legal;
    logic [CNT_W-1:0] base;
    logic             use_m;
    logic             use_x;
    logic             use_native;
    logic             dir_mode;
    logic             pc_ok;
  } lut_t;
endpackage

// File: rtl/cyc_base_lut.sv
module cyc_base_lut
  import cyc_pkg::*;
(
  input  logic [CLS_W-1:0]  cls_i,
  input  logic [MODE_W-1:0] mode_i,
  output lut_t              lut_o
);
  function automatic lut_t mk(input int unsigned b, input logic um, input logic ux,
                              input logic un, input logic pc);
    lut_t r;
    r.legal      = 1'b1;
    r.base       = CNT_W'(b);
    r.use_m      = um;
    r.use_x      = ux;
    r.use_native = un;
    r.dir_mode   = 1'b0;
    r.pc_ok      = pc;
    return r;
  endfunction

  logic is_dir;
  always_comb begin
    unique case (mode_i)
      AM_DIR, AM_DIR_IND, AM_DIR_IND_L, AM_DIR_X, AM_DIR_X_IND,
      AM_DIR_IND_Y, AM_DIR_INDL_Y, AM_DIR_Y, AM_DIR_Y_IDX: is_dir = 1'b1;
      default: is_dir = 1'b0;
    endcase
  end

  lut_t t;
  always_comb begin
    t = '0;
    unique case (cls_i)
      CLS_ACC_RD, CLS_ACC_ST: begin
        unique case (mode_i)
          AM_IMM:        if (cls_i == CLS_ACC_RD) t = mk(2, 1'b1, 1'b0, 1'b0, 1'b0);
          AM_ABS:        t = mk(4, 1'b1, 1'b0, 1'b0, 1'b0);
          AM_ABS_L:      t = mk(5, 1'b1, 1'b0, 1'b0, 1'b0);
          AM_DIR:        t = mk(3, 1'b1, 1'b0, 1'b0, 1'b0);
          AM_DIR_IND:    t = mk(5, 1'b1, 1'b0, 1'b0, 1'b0);
          AM_DIR_IND_L:  t = mk(6, 1'b1, 1'b0, 1'b0, 1'b0);
          AM_ABS_X, AM_ABS_Y:
            t = (cls_i == CLS_ACC_RD) ? mk(4, 1'b1, 1'b0, 1'b0, 1'b1)
                                      : mk(5, 1'b1, 1'b0, 1'b0, 1'b0);
          AM_ABS_L_X:    t = mk(5, 1'b1, 1'b0, 1'b0, 1'b0);
          AM_DIR_X:      t = mk(4, 1'b1, 1'b0, 1'b0, 1'b0);
          AM_DIR_X_IND:  t = mk(6, 1'b1, 1'b0, 1'b0, 1'b0);
          AM_DIR_IND_Y:
            t = (cls_i == CLS_ACC_RD) ? mk(5, 1'b1, 1'b0, 1'b0, 1'b1)
                                      : mk(6, 1'b1, 1'b0, 1'b0, 1'b0);
          AM_DIR_INDL_Y: t = mk(6, 1'b1, 1'b0, 1'b0, 1'b0);
          AM_STK:        t = mk(4, 1'b1, 1'b0, 1'b0, 1'b0);
          AM_STK_IND_Y:  t = mk(7, 1'b1, 1'b0, 1'b0, 1'b0);
          default:       t = '0;
        endcase
      end
      CLS_IDX_RD: begin
        unique case (mode_i)
          AM_IMM:             t = mk(2, 1'b0, 1'b1, 1'b0, 1'b0);
          AM_ABS:             t = mk(4, 1'b0, 1'b1, 1'b0, 1'b0);
          AM_DIR:             t = mk(3, 1'b0, 1'b1, 1'b0, 1'b0);
          AM_ABS_X, AM_ABS_Y: t = mk(4, 1'b0, 1'b1, 1'b0, 1'b1);
          AM_DIR_X, AM_DIR_Y_IDX: t = mk(4, 1'b0, 1'b1, 1'b0, 1'b0);
          default:            t = '0;
        endcase
      end
      CLS_CALL: begin
        unique case (mode_i)
          AM_ABS:       t = mk(6, 1'b0, 1'b0, 1'b0, 1'b0);
          AM_ABS_X_IND: t = mk(8, 1'b0, 1'b0, 1'b0, 1'b0);
          AM_ABS_L:     t = mk(8, 1'b0, 1'b0, 1'b0, 1'b0);
          default:      t = '0;
        endcase
      end
      default: begin
        // implicit classes: only the implied mode is legal
        if (mode_i == AM_IMPL) begin
          unique case (cls_i)
            CLS_TRAP:     t = mk(7, 1'b0, 1'b0, 1'b1, 1'b0);
            CLS_RET_INT:  t = mk(6, 1'b0, 1'b0, 1'b1, 1'b0);
            CLS_PSH_A:    t = mk(3, 1'b1, 1'b0, 1'b0, 1'b0);
            CLS_PSH_IDX:  t = mk(3, 1'b0, 1'b1, 1'b0, 1'b0);
            CLS_PSH_DB:   t = mk(3, 1'b0, 1'b0, 1'b0, 1'b0);
            CLS_PSH_DP:   t = mk(4, 1'b0, 1'b0, 1'b0, 1'b0);
            CLS_PSH_PB:   t = mk(3, 1'b0, 1'b0, 1'b0, 1'b0);
            CLS_PSH_ST:   t = mk(3, 1'b0, 1'b0, 1'b0, 1'b0);
            CLS_PUL_A:    t = mk(4, 1'b1, 1'b0, 1'b0, 1'b0);
            CLS_PUL_IDX:  t = mk(4, 1'b0, 1'b1, 1'b0, 1'b0);
            CLS_PUL_DB:   t = mk(4, 1'b0, 1'b0, 1'b0, 1'b0);
            CLS_PUL_DP:   t = mk(5, 1'b0, 1'b0, 1'b0, 1'b0);
            CLS_PUL_ST:   t = mk(4, 1'b0, 1'b0, 1'b0, 1'b0);
            CLS_STAT_BIT: t = mk(3, 1'b0, 1'b0, 1'b0, 1'b0);
            CLS_SIMPLE:   t = mk(2, 1'b0, 1'b0, 1'b0, 1'b0);
            default:      t = '0;
          endcase
        end
      end
    endcase
    t.dir_mode = t.legal & is_dir;
  end

  assign lut_o = t;
endmodule

// File: rtl/cyc_penalty.sv
module cyc_penalty
  import cyc_pkg::*;
#(
  parameter int unsigned N_PEN = NUM_PEN,
  localparam int unsigned SUM_W = $clog2(N_PEN + 1)
) (
  input  logic [N_PEN-1:0] pen_i,
  output logic [SUM_W-1:0] sum_o
);
  logic [SUM_W-1:0] part [N_PEN+1];
  assign part[0] = '0;
  for (genvar g = 0; g < N_PEN; g++) begin : g_acc
    assign part[g+1] = part[g] + SUM_W'(pen_i[g]);
  end
  assign sum_o = part[N_PEN];
endmodule

// File: rtl/cyc_count_calc.sv
module cyc_count_calc
  import cyc_pkg::*;
#(
  parameter int unsigned C_W = CLS_W,
  parameter int unsigned M_W = MODE_W,
  parameter int unsigned D_W = DP_W,
  parameter int unsigned O_W = CNT_W,
  localparam int unsigned SUM_W = $clog2(NUM_PEN + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [C_W-1:0] class_i,
  input  logic [M_W-1:0] mode_i,
  input  logic           flag_m_i,
  input  logic           flag_x_i,
  input  logic           emu_i,
  input  logic [D_W-1:0] dp_low_i,
  input  logic           page_cross_i,
  output logic           valid_o,
  output logic [O_W-1:0] cycles_o,
  output logic           illegal_o
);
  lut_t             lut;
  logic [NUM_PEN-1:0] pen;
  logic [SUM_W-1:0] pen_sum;
  logic [O_W-1:0]   cnt_d;

  cyc_base_lut u_lut (
    .cls_i  (CLS_W'(class_i)),
    .mode_i (MODE_W'(mode_i)),
    .lut_o  (lut)
  );

  always_comb begin
    pen[0] = lut.use_m & ~flag_m_i;
    pen[1] = lut.use_x & ~flag_x_i;
    pen[2] = lut.use_native & ~emu_i;
    pen[3] = lut.dir_mode & (|dp_low_i);
    pen[4] = lut.pc_ok & page_cross_i;
  end

  cyc_penalty #(.N_PEN(NUM_PEN)) u_pen (
    .pen_i (pen),
    .sum_o (pen_sum)
  );

  assign cnt_d = lut.legal ? (O_W'(lut.base) + O_W'(pen_sum)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      cycles_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      cycles_o  <= valid_i ? cnt_d : '0;
      illegal_o <= valid_i & ~lut.legal;
    end
  end
endmodule

// File: rtl/cyc_count_calc_chk.sv
module cyc_count_calc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [4:0] class_i,
  input logic       emu_i,
  input logic       valid_o,
  input logic [3:0] cycles_o,
  input logic       illegal_o
);
  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (cycles_o == 4'd0 && !illegal_o));
  // R11
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (cycles_o == 4'd0 && valid_o));
  // R3
  legal_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !illegal_o) |-> cycles_o >= 4'd2);
  // R8
  trap_native_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == 5'd3 && !emu_i) |=> (cycles_o == 4'd8 || illegal_o));
  // R11
  bad_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i > 5'd18) |=> illegal_o);
endmodule

bind cyc_count_calc cyc_count_calc_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .class_i   (class_i),
  .emu_i     (emu_i),
  .valid_o   (valid_o),
  .cycles_o  (cycles_o),
  .illegal_o (illegal_o)
);

// File: tb/cyc_count_calc_tb_top.sv
`timescale 1ns/100ps
module cyc_count_calc_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [4:0] class_i = '0;
  logic [4:0] mode_i = '0;
  logic       flag_m_i = 1'b1;
  logic       flag_x_i = 1'b1;
  logic       emu_i = 1'b1;
  logic [7:0] dp_low_i = '0;
  logic       page_cross_i = 1'b0;
  logic       valid_o;
  logic [3:0] cycles_o;
  logic       illegal_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  cyc_count_calc dut_i (.*);

  task automatic run(input int cls, input int md, input bit m, input bit x, input bit e,
                     input int dp, input bit pc, input int exp_cnt, input bit exp_ill,
                     input string req);
    @(negedge clk_i);
    valid_i = 1'b1; class_i = 5'(cls); mode_i = 5'(md);
    flag_m_i = m; flag_x_i = x; emu_i = e; dp_low_i = 8'(dp); page_cross_i = pc;
    @(negedge clk_i);
    valid_i = 1'b0;
    n_chk++;
    if (valid_o !== 1'b1 || cycles_o !== 4'(exp_cnt) || illegal_o !== exp_ill) begin
      n_fail++;
      $display("FAIL %s cls=%0d mode=%0d: got v=%b cnt=%0d ill=%b exp v=1 cnt=%0d ill=%b",
               req, cls, md, valid_o, cycles_o, illegal_o, exp_cnt, exp_ill);
    end
  endtask

  task automatic t_reset;
    n_chk++;
    if (valid_o !== 1'b0 || cycles_o !== 4'd0 || illegal_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 got v=%b cnt=%0d ill=%b exp 0 0 0", valid_o, cycles_o, illegal_o);
    end
  endtask

  task automatic t_idle;
    run(0, 2, 1, 1, 1, 0, 0, 4, 0, "R2");
    @(negedge clk_i);
    n_chk++;
    if (valid_o !== 1'b0 || cycles_o !== 4'd0 || illegal_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 idle got v=%b cnt=%0d ill=%b exp 0 0 0", valid_o, cycles_o, illegal_o);
    end
  endtask

  task automatic t_acc_read;
    run(0, 1, 1, 1, 1, 0, 0, 2, 0, "R3");
    run(0, 3, 1, 1, 1, 0, 0, 5, 0, "R3");
    run(0, 14, 1, 1, 1, 0, 0, 4, 0, "R3");
    run(0, 15, 1, 1, 1, 0, 0, 7, 0, "R3");
    run(0, 11, 1, 1, 1, 0, 0, 6, 0, "R3");
  endtask

  task automatic t_width;
    run(0, 1, 0, 1, 1, 0, 0, 3, 0, "R4");
    run(0, 2, 1, 0, 1, 0, 0, 4, 0, "R4");   // x flag ignored for acc class
    run(2, 1, 0, 1, 1, 0, 0, 2, 0, "R4");   // m flag ignored for index class
    run(7, 0, 0, 0, 1, 0, 0, 3, 0, "R4");
  endtask

  task automatic t_dir;
    run(0, 4, 1, 1, 1, 0, 0, 3, 0, "R5");
    run(0, 4, 1, 1, 1, 8'h12, 0, 4, 0, "R5");
    run(0, 2, 1, 1, 1, 8'h12, 0, 4, 0, "R5");
    run(0, 13, 1, 1, 1, 8'h80, 0, 7, 0, "R5");
  endtask

  task automatic t_cross;
    run(0, 12, 0, 1, 1, 8'h01, 1, 8, 0, "R6");
    run(0, 7, 1, 1, 1, 0, 1, 5, 0, "R6");
    run(0, 9, 0, 1, 1, 0, 1, 6, 0, "R6");
    run(0, 2, 1, 1, 1, 0, 1, 4, 0, "R6");
    run(0, 8, 1, 1, 1, 0, 1, 5, 0, "R6");
    run(2, 9, 1, 1, 1, 0, 1, 5, 0, "R6");
    run(2, 10, 1, 1, 1, 0, 1, 4, 0, "R6");
  endtask

  task automatic t_store;
    run(1, 7, 1, 1, 1, 0, 1, 5, 0, "R7");
    run(1, 9, 0, 1, 1, 0, 1, 6, 0, "R7");
    run(1, 12, 1, 1, 1, 0, 1, 6, 0, "R7");
    run(1, 4, 1, 1, 1, 8'h03, 0, 4, 0, "R7");
    run(1, 1, 1, 1, 1, 0, 0, 0, 1, "R7");
  endtask

  task automatic t_idx;
    run(2, 1, 1, 0, 1, 0, 0, 3, 0, "R12");
    run(2, 18, 1, 1, 1, 8'h04, 0, 5, 0, "R12");
    run(2, 4, 1, 1, 1, 0, 0, 3, 0, "R12");
    run(2, 3, 1, 1, 1, 0, 0, 0, 1, "R12");
  endtask

  task automatic t_trap;
    run(3, 0, 1, 1, 1, 0, 0, 7, 0, "R8");
    run(3, 0, 1, 1, 0, 0, 0, 8, 0, "R8");
    run(4, 0, 1, 1, 0, 0, 0, 7, 0, "R8");
    run(4, 0, 1, 1, 1, 0, 0, 6, 0, "R8");
  endtask

  task automatic t_stack;
    run(5, 0, 0, 1, 1, 0, 0, 4, 0, "R9");
    run(6, 0, 1, 0, 1, 0, 0, 4, 0, "R9");
    run(8, 0, 1, 1, 1, 0, 0, 4, 0, "R9");
    run(9, 0, 1, 1, 1, 0, 0, 3, 0, "R9");
    run(10, 0, 1, 1, 1, 0, 0, 3, 0, "R9");
    run(11, 0, 1, 1, 1, 0, 0, 4, 0, "R9");
    run(12, 0, 1, 0, 1, 0, 0, 5, 0, "R9");
    run(13, 0, 1, 1, 1, 0, 0, 4, 0, "R9");
    run(14, 0, 1, 1, 1, 8'hFF, 1, 5, 0, "R9");
    run(15, 0, 1, 1, 0, 0, 0, 4, 0, "R9");
  endtask

  task automatic t_misc;
    run(16, 2, 1, 1, 1, 0, 0, 6, 0, "R10");
    run(16, 16, 1, 1, 1, 0, 0, 8, 0, "R10");
    run(16, 3, 0, 0, 0, 0, 0, 8, 0, "R10");
    run(17, 0, 1, 1, 1, 0, 0, 3, 0, "R10");
    run(18, 0, 0, 0, 0, 0, 0, 2, 0, "R10");
  endtask

  task automatic t_illegal;
    run(25, 0, 1, 1, 1, 0, 0, 0, 1, "R11");
    run(5, 2, 1, 1, 1, 0, 0, 0, 1, "R11");
    run(0, 20, 1, 1, 1, 0, 0, 0, 1, "R11");
    run(16, 4, 1, 1, 1, 0, 0, 0, 1, "R11");
    run(0, 0, 1, 1, 1, 0, 0, 0, 1, "R11");
  endtask

  initial begin : watchdog
    #200000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_idle();
    t_acc_read();
    t_width();
    t_dir();
    t_cross();
    t_store();
    t_idx();
    t_trap();
    t_stack();
    t_misc();
    t_illegal();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule